// File: doc/BRIEF.md
# CPU Address Window Decoder

This block decodes each 32-bit CPU physical address against a bank of programmable windows. Software programs the windows through a word-wide register write/read port. Each window has a control word (enable, target, attribute, size mask) and a base word. The lowest-numbered windows also have a pair of remap words.

The decode path is purely combinational. For every `cpu_addr_i` it reports the following:
- whether any enabled window matched;
- the index, 4-bit target and 8-bit attribute of the winning window;
- a translated address.

On a window that has remap registers, the translated address replaces the address bits above the window size with the remap value. Other windows pass the address through unchanged.

The register map is irregular:
- The remappable windows use a 16-byte stride.
- A 16-byte reserved gap follows them.
- The remaining windows use an 8-byte stride that holds only control and base.

Register writes take effect at the next rising clock edge. Reads return data combinationally for the address on `reg_addr_i`.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every register reads zero, every window is disabled, and every CPU address misses.
- R2: Control word layout: bit 0 enables the window, bits 7:4 are the target, bits 15:8 the attribute, and bits 31:16 the size mask (size in 64 KB units minus one); bits 3:1 read back as zero.
- R3: Base word layout: bits 31:16 are the window base and bits 3:0 are extension bits that are stored and read back but take no part in matching; all other bits read zero.
- R4: Window w below 8 sits at byte offset 16*w: control +0x0, base +0x4, remap-low +0x8, remap-high +0xC. Window w from 8 to 19 sits at 0x90+8*(w-8): control +0x0, base +0x4. Register address bits 1:0 are ignored.
- R5: Offsets 0x80–0x8F and 0xF0–0xFF read zero, and writes there change no register.
- R6: An address matches a window when the window is enabled and address bits 31:16 equal base bits 31:16 at every bit where the size mask is zero; a disabled window never matches.
- R7: On a match `hit_o`=1 and `miss_o`=0, and `win_idx_o`, `target_o` and `attr_o` give the winning window's index and fields.
- R8: On no match `miss_o`=1, `hit_o`=0, the index, target and attribute are zero, and the translated address equals the input address.
- R9: When several windows match, the lowest-numbered one wins and `multi_hit_o` is 1; with a single match it is 0.
- R10: On a hit in window 0–7, translated bits 31:16 take remap-low bits where the size mask is 0 and address bits where it is 1; bits 15:0 always pass through.
- R11: On a hit in window 8–19, the translated address equals the input address.
- R12: Remap-low keeps bits 31:16 and reads zero in bits 15:0. Remap-high keeps all 32 bits and has no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| cpu_addr_i | input | 32 | CPU physical address to decode |
| hit_o | output | 1 | At least one window matched |
| miss_o | output | 1 | No window matched |
| multi_hit_o | output | 1 | Two or more windows matched |
| win_idx_o | output | 5 | Index of winning window |
| target_o | output | 4 | Target of winning window |
| attr_o | output | 8 | Attribute of winning window |
| xlat_addr_o | output | 32 | Translated address |

## Verification
The properties assume the following about the inputs:
- Register offsets and CPU addresses are stable around each rising edge.
- Size masks are contiguous low-order runs of ones, so that "above the window size" is well defined.

The directed stimulus therefore changes inputs only on falling edges. It programs only contiguous masks (zero, 0x000F, 0x00FF) and bases aligned to them. Overlap is created on purpose, between one remappable window and one plain window, to exercise priority and the multi-hit flag.

// File: rtl/awd_pkg.sv
package awd_pkg;
  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_BASE = 2'd1,
    FLD_RLO  = 2'd2,
    FLD_RHI  = 2'd3
  } fld_e;

  localparam int          DW        = 32;
  localparam int          WIDE_STR  = 16;
  localparam int          NARR_STR  = 8;
  localparam int          HOLE_SZ   = 16;
  localparam logic [31:0] CTRL_KEEP = 32'hFFFF_FFF1;
  localparam logic [31:0] BASE_KEEP = 32'hFFFF_000F;
  localparam logic [31:0] RLO_KEEP  = 32'hFFFF_0000;
  localparam int          EN_BIT    = 0;
  localparam int          TGT_LSB   = 4;
  localparam int          ATTR_LSB  = 8;
endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [REG_AW-1:0]             addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [DW-1:0]                 rdata_o,
  output logic [NUM_WIN-1:0][DW-1:0]    ctrl_o,
  output logic [NUM_WIN-1:0][DW-1:0]    base_o,
  output logic [NUM_WIN-1:0][DW-1:0]    rlo_o
);
  localparam int          IDX_W    = $clog2(NUM_WIN);
  localparam logic [31:0] WIDE_END = 32'(NUM_REMAP * WIDE_STR);
  localparam logic [31:0] NARR_BEG = 32'(NUM_REMAP * WIDE_STR + HOLE_SZ);
  localparam logic [31:0] NARR_END = 32'(NUM_REMAP * WIDE_STR + HOLE_SZ
                                         + (NUM_WIN - NUM_REMAP) * NARR_STR);

  logic [31:0]      a_w;
  logic             dec_valid;
  logic [IDX_W-1:0] dec_idx;
  fld_e             dec_fld;
  logic [NUM_WIN-1:0][DW-1:0] rhi_a;

  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  assign a_w = {{(32-REG_AW){1'b0}}, addr_i[REG_AW-1:2], 2'b00};

  // Irregular map: wide stride, reserved gap, narrow stride
  always_comb begin
    dec_valid = 1'b0;
    dec_idx   = '0;
    dec_fld   = FLD_CTRL;
    if (a_w < WIDE_END) begin
      dec_valid = 1'b1;
      dec_idx   = IDX_W'(a_w / 32'(WIDE_STR));
      dec_fld   = fld_e'(a_w[3:2]);
    end else if (a_w >= NARR_BEG && a_w < NARR_END) begin
      dec_valid = 1'b1;
      dec_idx   = IDX_W'(32'(NUM_REMAP) + (a_w - NARR_BEG) / 32'(NARR_STR));
      dec_fld   = a_w[2] ? FLD_BASE : FLD_CTRL;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic          sel;
    logic [DW-1:0] ctrl_r, base_r, rlo_r, rhi_r;

    assign sel = we_i && dec_valid && (dec_idx == IDX_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_r <= '0;
        base_r <= '0;
      end else if (sel) begin
        if (dec_fld == FLD_CTRL) ctrl_r <= wdata_i & CTRL_KEEP;
        if (dec_fld == FLD_BASE) base_r <= wdata_i & BASE_KEEP;
      end
    end

    if (w < NUM_REMAP) begin : g_rmp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rlo_r <= '0;
          rhi_r <= '0;
        end else if (sel) begin
          if (dec_fld == FLD_RLO) rlo_r <= wdata_i & RLO_KEEP;
          if (dec_fld == FLD_RHI) rhi_r <= wdata_i;
        end
      end
    end else begin : g_plain
      assign rlo_r = '0;
      assign rhi_r = '0;
    end

    assign ctrl_o[w] = ctrl_r;
    assign base_o[w] = base_r;
    assign rlo_o[w]  = rlo_r;
    assign rhi_a[w]  = rhi_r;
  end

  always_comb begin
    rdata_o = '0;
    if (dec_valid) begin
      unique case (dec_fld)
        FLD_CTRL: rdata_o = ctrl_o[dec_idx];
        FLD_BASE: rdata_o = base_o[dec_idx];
        FLD_RLO:  rdata_o = rlo_o[dec_idx];
        FLD_RHI:  rdata_o = rhi_a[dec_idx];
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/awd_match.sv
module awd_match
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 20
) (
  input  logic [DW-1:0]              addr_i,
  input  logic [NUM_WIN-1:0][DW-1:0] ctrl_i,
  input  logic [NUM_WIN-1:0][DW-1:0] base_i,
  output logic [NUM_WIN-1:0]         hit_o
);
  logic unused_addr;
  assign unused_addr = ^addr_i[15:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [15:0] msk;
    logic        unused_w;
    assign msk      = ctrl_i[w][31:16];
    assign unused_w = ^{ctrl_i[w][15:1], base_i[w][15:0]};
    assign hit_o[w] = ctrl_i[w][EN_BIT]
                    && (((addr_i[31:16] ^ base_i[w][31:16]) & ~msk) == 16'h0);
  end
endmodule

// File: rtl/awd_select.sv
module awd_select
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8
) (
  input  logic [DW-1:0]                addr_i,
  input  logic [NUM_WIN-1:0]           hit_i,
  input  logic [NUM_WIN-1:0][DW-1:0]   ctrl_i,
  input  logic [NUM_WIN-1:0][DW-1:0]   rlo_i,
  output logic                         hit_o,
  output logic                         multi_o,
  output logic [$clog2(NUM_WIN)-1:0]   idx_o,
  output logic [3:0]                   target_o,
  output logic [7:0]                   attr_o,
  output logic [DW-1:0]                xlat_o
);
  localparam int IDX_W = $clog2(NUM_WIN);

  logic             found;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    sel_ctrl, sel_rlo;
  logic [15:0]      msk;
  logic             remappable;
  logic             unused_sel;

  // Lowest index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (hit_i[w] && !found) begin
        found = 1'b1;
        idx   = IDX_W'(w);
      end
    end
  end

  assign sel_ctrl   = ctrl_i[idx];
  assign sel_rlo    = rlo_i[idx];
  assign msk        = sel_ctrl[31:16];
  assign remappable = found && ({1'b0, idx} < (IDX_W+1)'(NUM_REMAP));
  assign unused_sel = ^{sel_ctrl[3:0], sel_rlo[15:0]};

  assign hit_o    = found;
  assign multi_o  = (hit_i & (hit_i - 1'b1)) != '0;
  assign idx_o    = idx;
  assign target_o = found ? sel_ctrl[TGT_LSB +: 4]  : 4'h0;
  assign attr_o   = found ? sel_ctrl[ATTR_LSB +: 8] : 8'h00;
  assign xlat_o[15:0]  = addr_i[15:0];
  assign xlat_o[31:16] = remappable ? ((sel_rlo[31:16] & ~msk) | (addr_i[31:16] & msk))
                                    : addr_i[31:16];
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        reg_we_i,
  input  logic [REG_AW-1:0]           reg_addr_i,
  input  logic [31:0]                 reg_wdata_i,
  output logic [31:0]                 reg_rdata_o,
  input  logic [31:0]                 cpu_addr_i,
  output logic                        hit_o,
  output logic                        miss_o,
  output logic                        multi_hit_o,
  output logic [$clog2(NUM_WIN)-1:0]  win_idx_o,
  output logic [3:0]                  target_o,
  output logic [7:0]                  attr_o,
  output logic [31:0]                 xlat_addr_o
);
  logic [NUM_WIN-1:0][DW-1:0] ctrl_q, base_q, rlo_q;
  logic [NUM_WIN-1:0]         hit_vec;
  logic                       any_hit;

  awd_regs #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl_q),
    .base_o  (base_q),
    .rlo_o   (rlo_q)
  );

  awd_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr_i (cpu_addr_i),
    .ctrl_i (ctrl_q),
    .base_i (base_q),
    .hit_o  (hit_vec)
  );

  awd_select #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_sel (
    .addr_i   (cpu_addr_i),
    .hit_i    (hit_vec),
    .ctrl_i   (ctrl_q),
    .rlo_i    (rlo_q),
    .hit_o    (any_hit),
    .multi_o  (multi_hit_o),
    .idx_o    (win_idx_o),
    .target_o (target_o),
    .attr_o   (attr_o),
    .xlat_o   (xlat_addr_o)
  );

  assign hit_o  = any_hit;
  assign miss_o = ~any_hit;
endmodule

// File: rtl/addr_win_decoder_chk.sv
module addr_win_decoder_chk #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [REG_AW-1:0]          reg_addr_i,
  input logic [31:0]                reg_rdata_o,
  input logic [31:0]                cpu_addr_i,
  input logic                       hit_o,
  input logic                       miss_o,
  input logic                       multi_hit_o,
  input logic [$clog2(NUM_WIN)-1:0] win_idx_o,
  input logic [3:0]                 target_o,
  input logic [7:0]                 attr_o,
  input logic [31:0]                xlat_addr_o
);
  localparam logic [31:0] HOLE_LO = 32'(NUM_REMAP * 16);
  localparam logic [31:0] HOLE_HI = 32'(NUM_REMAP * 16 + 16);

  logic [31:0] ra;
  assign ra = 32'(reg_addr_i);

  // R8
  miss_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (!hit_o && target_o == 4'h0 && attr_o == 8'h00 && xlat_addr_o == cpu_addr_i));

  // R9
  multi_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> hit_o);

  // R10
  low_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlat_addr_o[15:0] == cpu_addr_i[15:0]);

  // R11
  plain_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && 32'(win_idx_o) >= 32'(NUM_REMAP)) |-> xlat_addr_o == cpu_addr_i);

  // R5
  hole_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra >= HOLE_LO && ra < HOLE_HI) |-> reg_rdata_o == 32'h0);

  // R7
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> 32'(win_idx_o) < 32'(NUM_WIN));
endmodule

bind addr_win_decoder addr_win_decoder_chk #(
  .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .cpu_addr_i  (cpu_addr_i),
  .hit_o       (hit_o),
  .miss_o      (miss_o),
  .multi_hit_o (multi_hit_o),
  .win_idx_o   (win_idx_o),
  .target_o    (target_o),
  .attr_o      (attr_o),
  .xlat_addr_o (xlat_addr_o)
);

// File: tb/addr_win_decoder_test.sv
`timescale 1ns/1ps
module addr_win_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  ra = 8'h00;
  logic [31:0] wd = 32'h0;
  logic [31:0] rd;
  logic [31:0] ca = 32'h0;
  logic        hit, miss, multi;
  logic [4:0]  idx;
  logic [3:0]  tgt;
  logic [7:0]  attr;
  logic [31:0] xlat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  addr_win_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .cpu_addr_i(ca), .hit_o(hit),
    .miss_o(miss), .multi_hit_o(multi), .win_idx_o(idx), .target_o(tgt),
    .attr_o(attr), .xlat_addr_o(xlat)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; ra = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    ra = a;
    #1;
    check(rd === exp, req, 64'(rd), 64'(exp));
  endtask

  // expected packing: hit,miss,multi,idx,tgt,attr,xlat
  task automatic probe(input logic [31:0] a, input bit eh, input bit em, input logic [4:0] ei,
                       input logic [3:0] et, input logic [7:0] ea, input logic [31:0] ex,
                       input string req);
    logic [63:0] act, exp;
    @(negedge clk);
    ca = a;
    #1;
    act = {11'b0, hit, miss, multi, idx, tgt, attr, xlat};
    exp = {11'b0, eh, ~eh, em, ei, et, ea, ex};
    check(act === exp, req, act, exp);
  endtask

  task automatic t_reset;
    rd_chk(8'h00, 32'h0, "R1 win0 ctrl");
    rd_chk(8'h78, 32'h0, "R1 win7 remap-low");
    rd_chk(8'hEC, 32'h0, "R1 win19 base");
    probe(32'h0000_0000, 0, 0, 5'd0, 4'h0, 8'h00, 32'h0000_0000, "R1 R8 miss at zero");
    probe(32'hDEAD_BEEF, 0, 0, 5'd0, 4'h0, 8'h00, 32'hDEAD_BEEF, "R1 R8 miss");
  endtask

  task automatic t_fields;
    wr(8'h30, 32'hFFFF_FFFF);
    rd_chk(8'h30, 32'hFFFF_FFF1, "R2 ctrl keep mask");
    wr(8'h30, 32'h0);
    wr(8'hA4, 32'hFFFF_FFFF);
    rd_chk(8'hA4, 32'hFFFF_000F, "R3 base keep mask");
    wr(8'hA4, 32'h0);
    wr(8'h58, 32'hFFFF_FFFF);
    rd_chk(8'h58, 32'hFFFF_0000, "R12 remap-low keep mask");
    wr(8'h58, 32'h0);
  endtask

  task automatic t_layout;
    wr(8'h7C, 32'h1357_9BDF);
    rd_chk(8'h7C, 32'h1357_9BDF, "R12 remap-high full");
    rd_chk(8'h7F, 32'h1357_9BDF, "R4 low addr bits ignored");
    wr(8'h90, 32'h0000_AA50);
    rd_chk(8'h90, 32'h0000_AA50, "R4 win8 ctrl at 0x90");
    wr(8'hEC, 32'h5555_0003);
    rd_chk(8'hEC, 32'h5555_0003, "R4 win19 base at 0xEC");
    rd_chk(8'hE8, 32'h0, "R4 win19 ctrl separate");
    wr(8'h90, 32'h0);
    wr(8'hEC, 32'h0);
  endtask

  task automatic t_hole;
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'hF0, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd_chk(8'h80, 32'h0, "R5 hole read");
    rd_chk(8'h8C, 32'h0, "R5 hole top read");
    rd_chk(8'hF0, 32'h0, "R5 tail read");
    rd_chk(8'h70, 32'h0, "R5 win7 ctrl untouched");
    rd_chk(8'h90, 32'h0, "R5 win8 ctrl untouched");
    probe(32'h0000_1234, 0, 0, 5'd0, 4'h0, 8'h00, 32'h0000_1234, "R5 no window enabled");
  endtask

  task automatic t_remap;
    wr(8'h24, 32'h1230_0000);
    wr(8'h28, 32'hABC0_FFFF);
    wr(8'h20, 32'h000F_A551);
    probe(32'h1237_5678, 1, 0, 5'd2, 4'h5, 8'hA5, 32'hABC7_5678, "R6 R7 R10 remap hit");
    probe(32'h123F_FFFF, 1, 0, 5'd2, 4'h5, 8'hA5, 32'hABCF_FFFF, "R10 top of window");
    probe(32'h1230_0000, 1, 0, 5'd2, 4'h5, 8'hA5, 32'hABC0_0000, "R10 bottom of window");
    probe(32'h1240_0000, 0, 0, 5'd0, 4'h0, 8'h00, 32'h1240_0000, "R6 above window");
    probe(32'h122F_FFFF, 0, 0, 5'd0, 4'h0, 8'h00, 32'h122F_FFFF, "R6 below window");
    wr(8'h24, 32'h1230_0007);
    probe(32'h1231_0000, 1, 0, 5'd2, 4'h5, 8'hA5, 32'hABC1_0000, "R3 ext bits ignored");
    wr(8'h2C, 32'hFFFF_FFFF);
    probe(32'h1231_0000, 1, 0, 5'd2, 4'h5, 8'hA5, 32'hABC1_0000, "R12 remap-high no effect");
  endtask

  task automatic t_plain;
    wr(8'hB4, 32'h4000_0000);
    wr(8'hB0, 32'h0000_3CC1);
    probe(32'h4000_BEEF, 1, 0, 5'd12, 4'hC, 8'h3C, 32'h4000_BEEF, "R11 plain hit");
    probe(32'h4001_0000, 0, 0, 5'd0, 4'h0, 8'h00, 32'h4001_0000, "R6 64KB boundary");
  endtask

  task automatic t_priority;
    wr(8'hCC, 32'h1200_0000);
    wr(8'hC8, 32'h00FF_1191);
    probe(32'h1237_5678, 1, 1, 5'd2, 4'h5, 8'hA5, 32'hABC7_5678, "R9 lowest wins, multi");
    probe(32'h1250_0000, 1, 0, 5'd15, 4'h9, 8'h11, 32'h1250_0000, "R9 single hit no multi");
    wr(8'h20, 32'h000F_A550);
    probe(32'h1237_5678, 1, 0, 5'd15, 4'h9, 8'h11, 32'h1237_5678, "R6 disabled never matches");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_layout();
    t_hole();
    t_remap();
    t_plain();
    t_priority();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule